// File: doc/BRIEF.md
# Masked Status-Register Interrupt Generator

This block watches a bank of 32 byte-wide status registers and raises an interrupt when a programmed pattern appears in one of them. The host picks a register by a 5-bit address and picks the bits that take part with an 8-bit mask. A mode bit sets how the masked bits combine: AND needs every one of them, OR needs any one. A 2-bit trigger field picks one of four tests: level set, level clear, rising edge or falling edge.

The test runs only on an evaluation strobe. A rate-select input picks either the per-sample strobe or the per-data-bit strobe. A passing test sets a sticky request bit that the block never clears; only the host clear input clears it. When interrupts are enabled, a passing test also sets an active bit and pulls the active-low interrupt line down.

Top module: `progint_top`

## Requirements
- R1: Only the register chosen by `addrSel` (byte `addrSel`, bits `8*addrSel+7 : 8*addrSel` of `regBank`) is tested. Changes to any other register have no effect on the outputs.
- R2: Only bits with a 1 in `bitMask` take part. When `bitMask` is zero, no trigger ever fires.
- R3: Trigger `trigSel`=00 (level set) fires on a strobe when all masked bits are 1 (`modeAnd`=1) or when any masked bit is 1 (`modeAnd`=0).
- R4: Trigger `trigSel`=01 (level clear) fires on a strobe when all masked bits are 0 (`modeAnd`=1) or when any masked bit is 0 (`modeAnd`=0).
- R5: The combined set condition is the one from R3. Trigger 10 fires on a strobe where this condition is 1 and was 0 at the previous strobe. Trigger 11 fires on a strobe where it is 0 and was 1 at the previous strobe.
- R6: A change of `addrSel` or `bitMask` discards the stored previous condition. No edge trigger can fire on the first strobe that follows the change, or on a strobe in the same cycle as the change.
- R7: Evaluation happens only in cycles where the selected strobe is high: `sampleStrobe` when `rateSel`=0, `bitStrobe` when `rateSel`=1. The other strobe is ignored.
- R8: `reqFlag` goes to 1 in the cycle after a firing strobe. It stays at 1 until a cycle with `reqClear` high. If a trigger fires in the same cycle as a clear, the set wins.
- R9: `activeFlag` goes to 1 in the cycle after a firing strobe while `intEnable` is 1. It drops after a cycle with `intEnable` low or with `reqClear` high and no new qualifying fire. `irqN` is always the inverse of `activeFlag`.
- R10: During and right after reset, `reqFlag`=0, `activeFlag`=0 and `irqN`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regBank | input | 256 | Flattened status registers; register k is in bits 8k+7:8k |
| addrSel | input | 5 | Register to test |
| bitMask | input | 8 | Bits of the register that take part |
| modeAnd | input | 1 | 1 = AND combining, 0 = OR combining |
| trigSel | input | 2 | 00 set, 01 clear, 10 rising, 11 falling |
| intEnable | input | 1 | Lets a fire assert the interrupt |
| rateSel | input | 1 | 0 = sample strobe, 1 = bit strobe |
| sampleStrobe | input | 1 | Per-sample evaluation pulse |
| bitStrobe | input | 1 | Per-data-bit evaluation pulse |
| reqClear | input | 1 | Host clear of request and active bits |
| reqFlag | output | 1 | Sticky request bit |
| activeFlag | output | 1 | Interrupt active status |
| irqN | output | 1 | Active-low interrupt line |

## Verification
A wrong stored previous condition or a stale address/mask copy shows up as a wrong edge fire. It appears on `reqFlag` one clock after the affected strobe. A fault in how the bits combine or in the strobe select also appears on `reqFlag` one cycle after the strobe. A fault in the request or active registers stays visible at `reqFlag`, `activeFlag` and `irqN` until the next clear or enable change. The bench therefore compares all three outputs with a behavioural model on every clock, so a fault is seen within one cycle of when it first has an effect.

// File: rtl/progint_pkg.sv
package progint_pkg;
  typedef enum logic [1:0] {
    TRIG_SET  = 2'b00,
    TRIG_CLR  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef struct packed {
    logic eval;
    logic rearm;
  } evalCtrl_t;
endpackage

// File: rtl/progint_datapath.sv
module progint_datapath
  import progint_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REGS*REG_W-1:0] regBank,
  input  logic [ADDR_W-1:0]         addrSel,
  input  logic [REG_W-1:0]          bitMask,
  input  logic                      modeAnd,
  input  logic [1:0]                trigSel,
  input  evalCtrl_t                 ctrl,
  output logic                      cfgChanged,
  output logic                      condHit
);
  logic [REG_W-1:0] regArr [NUM_REGS];
  logic [REG_W-1:0] selReg, setBits, clrBits;
  logic [ADDR_W-1:0] addrQ;
  logic [REG_W-1:0]  maskQ;
  logic maskNz, setCond, clrCond, prevQ, primedQ, edgeOk, rawHit;
  trig_e trig;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign regArr[g] = regBank[g*REG_W +: REG_W];
  end

  assign trig    = trig_e'(trigSel);
  assign selReg  = regArr[addrSel];
  assign setBits = selReg & bitMask;
  assign clrBits = ~selReg & bitMask;
  assign maskNz  = |bitMask;
  assign setCond = maskNz && (modeAnd ? (clrBits == '0) : (|setBits));
  assign clrCond = maskNz && (modeAnd ? (setBits == '0) : (|clrBits));
  assign edgeOk  = primedQ && !ctrl.rearm;

  assign cfgChanged = (addrSel != addrQ) || (bitMask != maskQ);

  always_comb begin
    unique case (trig)
      TRIG_SET:  rawHit = setCond;
      TRIG_CLR:  rawHit = clrCond;
      TRIG_RISE: rawHit = edgeOk && !prevQ && setCond;
      TRIG_FALL: rawHit = edgeOk && prevQ && !setCond;
      default:   rawHit = 1'b0;
    endcase
  end
  assign condHit = ctrl.eval && rawHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      maskQ   <= '0;
      prevQ   <= 1'b0;
      primedQ <= 1'b0;
    end else begin
      addrQ <= addrSel;
      maskQ <= bitMask;
      if (ctrl.eval) begin
        prevQ   <= setCond;
        primedQ <= 1'b1;
      end else if (ctrl.rearm) begin
        primedQ <= 1'b0;
      end
    end
  end

  p_zero_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bitMask == '0) |-> !condHit);
  p_hit_needs_eval_r7: assert property (@(posedge clk) disable iff (!rstN)
    condHit |-> ctrl.eval);
  p_no_edge_on_rearm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rearm && trigSel[1]) |-> !condHit);
endmodule

// File: rtl/progint_control.sv
module progint_control
  import progint_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rateSel,
  input  logic      sampleStrobe,
  input  logic      bitStrobe,
  input  logic      cfgChanged,
  input  logic      condHit,
  input  logic      intEnable,
  input  logic      reqClear,
  output evalCtrl_t ctrl,
  output logic      reqFlag,
  output logic      activeFlag,
  output logic      irqN
);
  logic reqQ, actQ;

  assign ctrl.eval  = rateSel ? bitStrobe : sampleStrobe;
  assign ctrl.rearm = cfgChanged;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= 1'b0;
      actQ <= 1'b0;
    end else begin
      if (condHit)       reqQ <= 1'b1;
      else if (reqClear) reqQ <= 1'b0;
      if (condHit && intEnable)        actQ <= 1'b1;
      else if (!intEnable || reqClear) actQ <= 1'b0;
    end
  end

  assign reqFlag    = reqQ;
  assign activeFlag = actQ;
  assign irqN       = ~actQ;

  p_req_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqFlag && !reqClear) |=> reqFlag);
  p_hit_sets_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    condHit |=> reqFlag);
  p_act_needs_en_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(activeFlag) |-> $past(intEnable));
  p_act_implies_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    activeFlag |-> reqFlag);
endmodule

// File: rtl/progint_top.sv
module progint_top
  import progint_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REGS*REG_W-1:0] regBank,
  input  logic [ADDR_W-1:0]         addrSel,
  input  logic [REG_W-1:0]          bitMask,
  input  logic                      modeAnd,
  input  logic [1:0]                trigSel,
  input  logic                      intEnable,
  input  logic                      rateSel,
  input  logic                      sampleStrobe,
  input  logic                      bitStrobe,
  input  logic                      reqClear,
  output logic                      reqFlag,
  output logic                      activeFlag,
  output logic                      irqN
);
  evalCtrl_t ctrl;
  logic cfgChanged, condHit;

  progint_datapath #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .regBank(regBank), .addrSel(addrSel),
    .bitMask(bitMask), .modeAnd(modeAnd), .trigSel(trigSel), .ctrl(ctrl),
    .cfgChanged(cfgChanged), .condHit(condHit)
  );

  progint_control u_ctl (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .sampleStrobe(sampleStrobe),
    .bitStrobe(bitStrobe), .cfgChanged(cfgChanged), .condHit(condHit),
    .intEnable(intEnable), .reqClear(reqClear), .ctrl(ctrl),
    .reqFlag(reqFlag), .activeFlag(activeFlag), .irqN(irqN)
  );
endmodule

// File: tb/tb_progint_top.sv
module tb_progint_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [255:0] regBank = '0;
  logic [4:0]   addrSel = '0;
  logic [7:0]   bitMask = '0;
  logic         modeAnd = 1'b0;
  logic [1:0]   trigSel = '0;
  logic         intEnable = 1'b0;
  logic         rateSel = 1'b0;
  logic         sampleStrobe = 1'b0;
  logic         bitStrobe = 1'b0;
  logic         reqClear = 1'b0;
  logic         reqFlag, activeFlag, irqN;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string curReq = "R10";

  // behavioural reference state
  bit mReq, mAct, mPrev, mPrimed;
  int mAddr, mMask;

  always #2 clk = ~clk;

  progint_top dut (
    .clk(clk), .rstN(rstN), .regBank(regBank), .addrSel(addrSel),
    .bitMask(bitMask), .modeAnd(modeAnd), .trigSel(trigSel),
    .intEnable(intEnable), .rateSel(rateSel), .sampleStrobe(sampleStrobe),
    .bitStrobe(bitStrobe), .reqClear(reqClear), .reqFlag(reqFlag),
    .activeFlag(activeFlag), .irqN(irqN)
  );

  function automatic bit levelOf(input bit wantSet);
    int nMask = 0;
    int nSet = 0;
    for (int b = 0; b < 8; b++) begin
      if (bitMask[b]) begin
        nMask++;
        if (regBank[addrSel*8 + b]) nSet++;
      end
    end
    if (nMask == 0) return 1'b0;
    if (wantSet) return modeAnd ? (nSet == nMask) : (nSet > 0);
    return modeAnd ? (nSet == 0) : (nSet < nMask);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReq = 0; mAct = 0; mPrev = 0; mPrimed = 0; mAddr = 0; mMask = 0;
    end else begin
      bit ev, chg, lvl, fire;
      ev  = rateSel ? bitStrobe : sampleStrobe;
      chg = (int'(addrSel) != mAddr) || (int'(bitMask) != mMask);
      lvl = levelOf(1'b1);
      fire = 0;
      if (ev) begin
        case (trigSel)
          2'd0: fire = lvl;
          2'd1: fire = levelOf(1'b0);
          2'd2: fire = mPrimed && !chg && !mPrev && lvl;
          default: fire = mPrimed && !chg && mPrev && !lvl;
        endcase
      end
      if (ev) begin mPrev = lvl; mPrimed = 1; end
      else if (chg) mPrimed = 0;
      mAddr = addrSel; mMask = bitMask;
      if (fire) mReq = 1; else if (reqClear) mReq = 0;
      if (fire && intEnable) mAct = 1;
      else if (!intEnable || reqClear) mAct = 0;
    end
  end

  task automatic check(input string tag, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, actual, expected, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check({curReq, " R8 reqFlag"}, reqFlag, mReq);
      check({curReq, " R9 activeFlag"}, activeFlag, mAct);
      check({curReq, " R9 irqN"}, irqN, ~mAct);
    end
  end

  task automatic setReg(input int idx, input logic [7:0] v);
    regBank[idx*8 +: 8] = v;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    sampleStrobe = 1; cyc(1); sampleStrobe = 0; cyc(1);
  endtask

  task automatic clearReq();
    reqClear = 1; cyc(1); reqClear = 0; cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(2);
    // R10 reset state
    check("R10 reqFlag in reset", reqFlag, 1'b0);
    check("R10 irqN in reset", irqN, 1'b1);
    rstN = 1; cyc(1);
    check("R10 activeFlag after reset", activeFlag, 1'b0);

    // R3 AND / OR set level
    curReq = "R3";
    intEnable = 1; addrSel = 5; bitMask = 8'hF0; modeAnd = 1; trigSel = 2'd0; cyc(1);
    setReg(5, 8'hE0); strobe();
    check("R3 AND partial no fire", reqFlag, 1'b0);
    setReg(5, 8'hF3); strobe();
    check("R3 AND all set fires", reqFlag, 1'b1);
    check("R9 irqN low on fire", irqN, 1'b0);
    clearReq();
    check("R8 host clear", reqFlag, 1'b0);
    modeAnd = 0; setReg(5, 8'h10); strobe();
    check("R3 OR any set fires", reqFlag, 1'b1);
    clearReq();

    // R1 other registers ignored
    curReq = "R1";
    setReg(5, 8'h00); setReg(6, 8'hFF); setReg(4, 8'hFF); strobe(); strobe();
    check("R1 unselected regs ignored", reqFlag, 1'b0);

    // R2 mask selection and zero mask
    curReq = "R2";
    setReg(5, 8'h0F); strobe();
    check("R2 unmasked bits ignored", reqFlag, 1'b0);
    bitMask = 8'h00; setReg(5, 8'hFF); strobe();
    trigSel = 2'd1; setReg(5, 8'h00); strobe(); modeAnd = 1; strobe();
    check("R2 zero mask never fires", reqFlag, 1'b0);

    // R4 clear level
    curReq = "R4";
    bitMask = 8'h0F; modeAnd = 1; setReg(5, 8'h01); cyc(1); strobe();
    check("R4 AND one bit set no fire", reqFlag, 1'b0);
    modeAnd = 0; strobe();
    check("R4 OR any clear fires", reqFlag, 1'b1);
    clearReq();

    // R5 edges
    curReq = "R5";
    trigSel = 2'd2; modeAnd = 1; setReg(5, 8'h00); strobe(); strobe();
    check("R5 no rise on steady low", reqFlag, 1'b0);
    setReg(5, 8'h0F); strobe();
    check("R5 rise fires", reqFlag, 1'b1);
    clearReq(); strobe();
    check("R5 no rise on steady high", reqFlag, 1'b0);
    trigSel = 2'd3; setReg(5, 8'h07); strobe();
    check("R5 fall fires", reqFlag, 1'b1);
    clearReq();

    // R6 rearm on address / mask change
    curReq = "R6";
    trigSel = 2'd2; setReg(5, 8'h00); setReg(7, 8'h0F); strobe();
    addrSel = 7; cyc(1); strobe();
    check("R6 no spurious rise after addr change", reqFlag, 1'b0);
    strobe();
    setReg(7, 8'h00); strobe();
    bitMask = 8'h00; sampleStrobe = 1; cyc(1); sampleStrobe = 0; cyc(1);
    setReg(7, 8'hFF); bitMask = 8'h0F; sampleStrobe = 1; cyc(1); sampleStrobe = 0; cyc(1);
    check("R6 no rise with same-cycle mask change", reqFlag, 1'b0);

    // R7 strobe select
    curReq = "R7";
    trigSel = 2'd0; rateSel = 1; strobe();
    check("R7 sample strobe ignored when bit rate", reqFlag, 1'b0);
    bitStrobe = 1; cyc(1); bitStrobe = 0; cyc(1);
    check("R7 bit strobe evaluates", reqFlag, 1'b1);
    clearReq();
    rateSel = 0; bitStrobe = 1; cyc(1); bitStrobe = 0; cyc(1);
    check("R7 bit strobe ignored when sample rate", reqFlag, 1'b0);

    // R8 set wins over simultaneous clear
    curReq = "R8";
    strobe();
    sampleStrobe = 1; reqClear = 1; cyc(1); sampleStrobe = 0; reqClear = 0; cyc(1);
    check("R8 set beats clear", reqFlag, 1'b1);
    cyc(3);
    check("R8 sticky without clear", reqFlag, 1'b1);
    clearReq();

    // R9 enable gating
    curReq = "R9";
    intEnable = 0; strobe();
    check("R9 disabled keeps irqN high", irqN, 1'b1);
    check("R9 disabled still requests", reqFlag, 1'b1);
    intEnable = 1; strobe();
    check("R9 enabled asserts active", activeFlag, 1'b1);
    intEnable = 0; cyc(1);
    check("R9 disable clears active", activeFlag, 1'b0);
    intEnable = 1; clearReq();

    // random traffic against the model
    curReq = "R1..random";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      regBank[$urandom_range(255)] = $urandom_range(1);
      if ($urandom_range(15) == 0) addrSel = 5'($urandom_range(7));
      if ($urandom_range(15) == 0) bitMask = 8'($urandom);
      if ($urandom_range(31) == 0) trigSel = 2'($urandom);
      if ($urandom_range(31) == 0) modeAnd = ~modeAnd;
      if ($urandom_range(31) == 0) rateSel = ~rateSel;
      if ($urandom_range(31) == 0) intEnable = ~intEnable;
      sampleStrobe = ($urandom_range(3) == 0);
      bitStrobe    = ($urandom_range(5) == 0);
      reqClear     = ($urandom_range(9) == 0);
    end
    sampleStrobe = 0; bitStrobe = 0; reqClear = 0; cyc(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule